// File: doc/BRIEF.md
# Two-Wire Serial Slave with Event Status Codes

This block is the target side of a byte-oriented two-wire serial bus (the usual clock line and open-drain data line). It is programmed with a 7-bit own address and, if wanted, also answers the all-zero broadcast address. It then waits for a START. If the address byte matches, it becomes a receiver or a transmitter, depending on the direction bit that follows the address.

Host software drives the block through a small set of signals and needs no state machine of its own. After every significant bus event the block raises an interrupt flag and presents an 8-bit status code, and software chooses its next step from that code. While the flag is set after a byte, the block holds the clock line low, so the bus waits until software has read or supplied the data and cleared the flag.

A single acknowledge-enable input does two jobs. It gates address recognition, and when cleared it makes the block refuse the next received byte or mark the next transmitted byte as the last one. Both bus lines are sampled by the fast system clock through synchroniser flops. START and STOP are found as data-line edges while the clock line is high.

Top module: `i2cs_slave`

## Requirements
- R1: After reset irq_o is 0, status_o reads F8h, and both scl_oe_o and sda_oe_o are 0, so the lines are released.
- R2: When enable_i and ack_en_i are 1, a START followed by the own address (the 7 upper bits of the frame, MSB first) with a direction bit of 0 is acknowledged by driving SDA low on the ninth clock. At the falling edge of that clock irq_o becomes 1 with status 60h. Any other address gets no acknowledge and no flag.
- R3: An own address with a direction bit of 1 is acknowledged and reports A8h. A byte written through data_wr_i/data_i while the block waits to transmit is driven onto SDA MSB first, one bit per SCL low phase.
- R4: The address byte 00h with a direction bit of 0 is acknowledged with status 70h only when gc_en_i is 1. When gc_en_i is 0 it gets no acknowledge and no flag.
- R5: While ack_en_i is 0 the own address is neither acknowledged nor flagged. Once ack_en_i is set again, the next START with the own address is recognised as normal.
- R6: In receive mode each data byte appears on rx_data_o with status 80h (own address) or 90h (general call) when ack_en_i was 1 at the end of its eighth bit. If ack_en_i was 0, SDA stays high in the ninth clock, the status is 88h or 98h, and the block returns to the not-addressed state.
- R7: In transmit mode, an acknowledge from the master gives B8h. A NACK gives C0h and returns the block to the not-addressed state. A byte loaded while ack_en_i was 0 is the last one: an acknowledge after it gives C8h and also ends the transfer.
- R8: A STOP or a repeated START seen while the block is addressed in a data phase sets irq_o with status A0h, without stretching the clock.
- R9: While the flag set by a byte event is pending, scl_oe_o is 1. The stretch only ever begins while the clock line is already low, and a flag_clr_i pulse releases SCL on the next cycle.
- R10: While irq_o is 0, status_o reads F8h.
- R11: With enable_i at 0 the block ignores the bus: no acknowledge and no flag. From the cycle after enable_i goes low, both line enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable |
| ack_en_i | input | 1 | Acknowledge enable: address recognition and byte ACK |
| gc_en_i | input | 1 | Also answer the all-zero broadcast address |
| own_addr_i | input | ADDR_W | Own 7-bit slave address |
| flag_clr_i | input | 1 | Single-cycle pulse that clears the interrupt flag |
| data_wr_i | input | 1 | Load data_i as the next byte to transmit |
| data_i | input | ADDR_W+1 | Byte to transmit |
| rx_data_o | output | ADDR_W+1 | Last byte received |
| status_o | output | 8 | Event status code (F8h when no flag) |
| irq_o | output | 1 | Interrupt flag |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The hardest situations to reach are those where software changes a control bit in the middle of a transfer and the effect shows up one byte later. These are the cleared acknowledge enable that refuses the next received byte (88h/98h), and the byte loaded with acknowledge enable clear that turns into C8h. The bench reaches them by changing ack_en_i while the block holds the clock low after a flagged event. At that moment the bus is frozen, so the change falls between two exact bytes. Repeated START while addressed is produced the same way, with the master issuing a new START right after a released data-phase flag.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ST_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,   // not addressed, waiting for START
        PH_ADDR,   // shifting in address frame
        PH_AACK,   // driving address acknowledge
        PH_RXD,    // receiving data bits
        PH_RACK,   // acknowledge slot after a received byte
        PH_TXD,    // transmitting data bits
        PH_TACK    // master acknowledge slot after a sent byte
    } phase_e;

    localparam logic [ST_W-1:0] ST_OWN_W   = 8'h60;
    localparam logic [ST_W-1:0] ST_GC      = 8'h70;
    localparam logic [ST_W-1:0] ST_RX_ACK  = 8'h80;
    localparam logic [ST_W-1:0] ST_RX_NACK = 8'h88;
    localparam logic [ST_W-1:0] ST_GC_ACK  = 8'h90;
    localparam logic [ST_W-1:0] ST_GC_NACK = 8'h98;
    localparam logic [ST_W-1:0] ST_END     = 8'hA0;
    localparam logic [ST_W-1:0] ST_OWN_R   = 8'hA8;
    localparam logic [ST_W-1:0] ST_TX_ACK  = 8'hB8;
    localparam logic [ST_W-1:0] ST_TX_NACK = 8'hC0;
    localparam logic [ST_W-1:0] ST_TX_LAST = 8'hC8;
    localparam logic [ST_W-1:0] ST_NONE    = 8'hF8;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], line_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign rise_o  = sync_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   frame_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic              gc_en_i,
    input  logic              enable_i,
    input  logic              ack_en_i,
    output logic              hit_o,
    output logic              gc_hit_o
);

    logic own_hit;
    logic bcast;

    always_comb begin
        bcast    = (frame_i[ADDR_W:1] == '0);
        own_hit  = !bcast && (frame_i[ADDR_W:1] == own_i);
        gc_hit_o = bcast && gc_en_i && !frame_i[0];
        hit_o    = enable_i && ack_en_i && (own_hit || gc_hit_o);
    end

endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                ack_en_i,
    input  logic                gc_en_i,
    input  logic [ADDR_W-1:0]   own_addr_i,
    input  logic                flag_clr_i,
    input  logic                data_wr_i,
    input  logic [ADDR_W:0]     data_i,
    output logic [ADDR_W:0]     rx_data_o,
    output logic [ST_W-1:0]     status_o,
    output logic                irq_o,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_oe_o,
    output logic                sda_oe_o
);

    localparam int DATA_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              rw;
        logic              gc;
        logic              ack;
        logic              last;
        logic              irq;
        logic              hold;
        logic [ST_W-1:0]   st;
        logic [DATA_W-1:0] rxd;
    } regs_t;

    regs_t q, d;

    // index 0: clock line, index 1: data line
    logic [1:0] lines, lvl, rise, fall;
    assign lines = {sda_i, scl_i};

    for (genvar i = 0; i < 2; i++) begin : g_sync
        i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .line_i  (lines[i]),
            .level_o (lvl[i]),
            .rise_o  (rise[i]),
            .fall_o  (fall[i])
        );
    end

    logic bus_start, bus_stop;
    assign bus_start = fall[1] & lvl[0];
    assign bus_stop  = rise[1] & lvl[0];

    logic hit, gc_hit;
    i2cs_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .frame_i  (q.sh),
        .own_i    (own_addr_i),
        .gc_en_i  (gc_en_i),
        .enable_i (enable_i),
        .ack_en_i (ack_en_i),
        .hit_o    (hit),
        .gc_hit_o (gc_hit)
    );

    logic addressed;

    always_comb begin
        d = q;
        addressed = q.ph inside {PH_RXD, PH_RACK, PH_TXD, PH_TACK};

        if (flag_clr_i) begin
            d.irq  = 1'b0;
            d.hold = 1'b0;
        end
        if (data_wr_i && q.ph == PH_TXD && q.cnt == '0) begin
            d.sh   = data_i;
            d.last = ~ack_en_i;
        end

        if (!enable_i) begin
            d.ph   = PH_IDLE;
            d.cnt  = '0;
            d.irq  = 1'b0;
            d.hold = 1'b0;
        end else if (bus_start || bus_stop) begin
            if (addressed) begin
                d.irq  = 1'b1;
                d.hold = 1'b0;
                d.st   = ST_END;
            end
            d.ph  = bus_start ? PH_ADDR : PH_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.ph)
                PH_ADDR, PH_RXD: begin
                    if (rise[0]) begin
                        d.sh  = {q.sh[DATA_W-2:0], lvl[1]};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall[0] && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        if (q.ph == PH_RXD) begin
                            d.ph  = PH_RACK;
                            d.ack = ack_en_i;
                        end else if (hit) begin
                            d.ph = PH_AACK;
                            d.rw = q.sh[0];
                            d.gc = gc_hit;
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                PH_AACK: begin
                    if (fall[0]) begin
                        d.irq  = 1'b1;
                        d.hold = 1'b1;
                        d.st   = q.gc ? ST_GC : (q.rw ? ST_OWN_R : ST_OWN_W);
                        d.ph   = q.rw ? PH_TXD : PH_RXD;
                        d.sh   = '1;
                    end
                end
                PH_RACK: begin
                    if (fall[0]) begin
                        d.irq  = 1'b1;
                        d.hold = 1'b1;
                        d.rxd  = q.sh;
                        if (q.gc) d.st = q.ack ? ST_GC_ACK : ST_GC_NACK;
                        else      d.st = q.ack ? ST_RX_ACK : ST_RX_NACK;
                        d.ph   = q.ack ? PH_RXD : PH_IDLE;
                    end
                end
                PH_TXD: begin
                    if (rise[0]) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall[0]) begin
                        if (q.cnt == LAST_BIT) begin
                            d.ph  = PH_TACK;
                            d.cnt = '0;
                            d.sh  = '1;
                        end else if (q.cnt != '0) begin
                            d.sh = {q.sh[DATA_W-2:0], 1'b1};
                        end
                    end
                end
                PH_TACK: begin
                    if (rise[0]) begin
                        d.ack = ~lvl[1];
                    end else if (fall[0]) begin
                        d.irq  = 1'b1;
                        d.hold = 1'b1;
                        d.sh   = '1;
                        if (!q.ack) begin
                            d.st = ST_TX_NACK;
                            d.ph = PH_IDLE;
                        end else if (q.last) begin
                            d.st = ST_TX_LAST;
                            d.ph = PH_IDLE;
                        end else begin
                            d.st = ST_TX_ACK;
                            d.ph = PH_TXD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{ph: PH_IDLE, cnt: '0, sh: '1, rw: 1'b0, gc: 1'b0,
                   ack: 1'b0, last: 1'b0, irq: 1'b0, hold: 1'b0,
                   st: ST_NONE, rxd: '0};
        end else begin
            q <= d;
        end
    end

    assign irq_o     = q.irq;
    assign status_o  = q.irq ? q.st : ST_NONE;
    assign rx_data_o = q.rxd;
    assign scl_oe_o  = q.irq & q.hold;
    assign sda_oe_o  = (q.ph == PH_AACK)
                     | ((q.ph == PH_RACK) & q.ack)
                     | ((q.ph == PH_TXD) & ~q.sh[DATA_W-1]);

endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       enable_i,
    input logic       flag_clr_i,
    input logic       scl_i,
    input logic       irq_o,
    input logic [7:0] status_o,
    input logic       scl_oe_o,
    input logic       sda_oe_o
);

    // R11
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!sda_oe_o && !scl_oe_o));

    // R10
    flag_has_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (status_o != 8'hF8));

    // R9
    stretch_from_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_oe_o) |-> !$past(scl_i));

    // R9
    clear_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_clr_i |=> !scl_oe_o);

    // R8
    end_no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && status_o == 8'hA0) |-> !scl_oe_o);

endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .flag_clr_i (flag_clr_i),
    .scl_i      (scl_i),
    .irq_o      (irq_o),
    .status_o   (status_o),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
);

// File: tb/i2cs_slave_tb_top.sv
module i2cs_slave_tb_top;

    localparam int Q = 8;   // system clocks per quarter bit

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       enable = 1'b0, ack_en = 1'b0, gc_en = 1'b0;
    logic       flag_clr = 1'b0, data_wr = 1'b0;
    logic [6:0] own = 7'h5A;
    logic [7:0] din = 8'h00;
    logic [7:0] rx_data, status;
    logic       irq, scl_oe, sda_oe;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_line, sda_line;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2cs_slave dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ack_en_i(ack_en),
        .gc_en_i(gc_en), .own_addr_i(own), .flag_clr_i(flag_clr),
        .data_wr_i(data_wr), .data_i(din), .rx_data_o(rx_data),
        .status_o(status), .irq_o(irq), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
    );

    int  n_chk = 0, n_fail = 0, c_chk = 0, c_fail = 0;
    bit  done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic raise_scl();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; quarter();
        raise_scl(); quarter();
        m_sda = 1'b0; quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; quarter();
        raise_scl(); quarter();
        m_sda = 1'b1; quarter();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; quarter();
        raise_scl(); quarter(); quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; quarter();
        raise_scl(); quarter();
        b = sda_line; quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ackbit);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ackbit);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(mack);
    endtask

    task automatic sw_clear();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk) begin data_wr = 1'b1; din = v; end
        @(negedge clk) data_wr = 1'b0;
    endtask

    task automatic expect_evt(input string req, input logic [7:0] code, input logic stretch);
        check(req, irq, 1'b1);
        check(req, status, code);
        check({req, " stretch"}, scl_oe, stretch);
    endtask

    // every-clock model comparison: no flag means idle code and free clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            c_chk++;
            if (!irq && (status !== 8'hF8 || scl_oe !== 1'b0)) begin
                c_fail++;
                $display("FAIL R10: actual status %0h scl_oe %0b expected F8 0", status, scl_oe);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk + c_chk + 1, n_fail + c_fail + 1);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", irq, 1'b0);
        check("R1 status", status, 8'hF8);
        check("R1 sda_oe", sda_oe, 1'b0);
        check("R1 scl_oe", scl_oe, 1'b0);

        enable = 1'b1; ack_en = 1'b1; gc_en = 1'b1;

        // R2 own address write, R6 data bytes
        bus_start();
        send_byte({7'h5A, 1'b0}, a);
        check("R2 addr ack", a, 1'b0);
        expect_evt("R2", 8'h60, 1'b1);
        check("R9 line held", scl_line, 1'b0);
        sw_clear();
        check("R9 released", scl_oe, 1'b0);
        send_byte(8'hC3, a);
        check("R6 data ack", a, 1'b0);
        expect_evt("R6", 8'h80, 1'b1);
        check("R6 rx data", rx_data, 8'hC3);
        ack_en = 1'b0;
        sw_clear();
        send_byte(8'h3C, a);
        check("R6 nack", a, 1'b1);
        expect_evt("R6", 8'h88, 1'b1);
        check("R6 rx data nack", rx_data, 8'h3C);
        ack_en = 1'b1;
        sw_clear();
        bus_stop();
        check("R6 not addressed after nack", irq, 1'b0);

        // R8 stop while addressed
        bus_start();
        send_byte({7'h5A, 1'b0}, a);
        expect_evt("R2", 8'h60, 1'b1);
        sw_clear();
        send_byte(8'h11, a);
        expect_evt("R6", 8'h80, 1'b1);
        sw_clear();
        bus_stop();
        expect_evt("R8 stop", 8'hA0, 1'b0);
        sw_clear();

        // R4 general call with enable
        bus_start();
        send_byte(8'h00, a);
        check("R4 gc ack", a, 1'b0);
        expect_evt("R4", 8'h70, 1'b1);
        sw_clear();
        send_byte(8'hA5, a);
        expect_evt("R6 gc", 8'h90, 1'b1);
        check("R6 gc rx", rx_data, 8'hA5);
        ack_en = 1'b0;
        sw_clear();
        send_byte(8'h5C, a);
        check("R6 gc nack", a, 1'b1);
        expect_evt("R6 gc", 8'h98, 1'b1);
        ack_en = 1'b1;
        sw_clear();
        bus_stop();

        // R4 general call disabled
        gc_en = 1'b0;
        bus_start();
        send_byte(8'h00, a);
        check("R4 gc ignored ack", a, 1'b1);
        check("R4 gc ignored irq", irq, 1'b0);
        bus_stop();

        // R2 foreign address
        bus_start();
        send_byte({7'h22, 1'b0}, a);
        check("R2 foreign ack", a, 1'b1);
        check("R2 foreign irq", irq, 1'b0);
        bus_stop();

        // R5 acknowledge enable gating address
        ack_en = 1'b0;
        bus_start();
        send_byte({7'h5A, 1'b0}, a);
        check("R5 gated ack", a, 1'b1);
        check("R5 gated irq", irq, 1'b0);
        bus_stop();
        ack_en = 1'b1;
        bus_start();
        send_byte({7'h5A, 1'b0}, a);
        check("R5 resumed ack", a, 1'b0);
        expect_evt("R5", 8'h60, 1'b1);
        sw_clear();

        // R8 repeated start, then R3/R7 transmit
        bus_start();
        expect_evt("R8 rstart", 8'hA0, 1'b0);
        sw_clear();
        send_byte({7'h5A, 1'b1}, a);
        check("R3 addr ack", a, 1'b0);
        expect_evt("R3", 8'hA8, 1'b1);
        load_tx(8'h96);
        sw_clear();
        recv_byte(v, 1'b0);
        check("R3 tx byte", v, 8'h96);
        expect_evt("R7 ack", 8'hB8, 1'b1);
        load_tx(8'h5B);
        sw_clear();
        recv_byte(v, 1'b1);
        check("R3 tx byte2", v, 8'h5B);
        expect_evt("R7 nack", 8'hC0, 1'b1);
        check("R7 sda released", sda_oe, 1'b0);
        sw_clear();
        bus_stop();
        check("R7 not addressed", irq, 1'b0);

        // R7 last byte
        bus_start();
        send_byte({7'h5A, 1'b1}, a);
        expect_evt("R3", 8'hA8, 1'b1);
        ack_en = 1'b0;
        load_tx(8'h7E);
        ack_en = 1'b1;
        sw_clear();
        recv_byte(v, 1'b0);
        check("R7 last data", v, 8'h7E);
        expect_evt("R7 last", 8'hC8, 1'b1);
        sw_clear();
        bus_stop();
        check("R7 last ends", irq, 1'b0);

        // R11 disabled
        enable = 1'b0;
        bus_start();
        send_byte({7'h5A, 1'b0}, a);
        check("R11 no ack", a, 1'b1);
        check("R11 no irq", irq, 1'b0);
        check("R11 sda free", sda_oe, 1'b0);
        bus_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + c_chk, n_fail + c_fail);
        $finish;
    end

endmodule